// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block moves incoming Ethernet frames from a byte stream into host memory. The host builds a ring of descriptors, each four 32-bit words long: status, control, buffer address and a next-pointer word that this engine never reads. The host gives the engine the ring base address and sets a run bit. The engine then steps through the ring in order. Each descriptor whose ownership bit is set receives one frame. The frame goes into the buffer named by the descriptor. The engine then writes the status word, which clears ownership and hands the descriptor back to the host.

The frame source presents one byte per beat, with a last-byte flag and an error flag. The engine holds the source off with `rx_ready` while it is busy on memory. The memory port carries one access at a time: a request is held until the memory acknowledges it, and read data arrives with that acknowledge. Bytes are packed little-endian into 32-bit words and written with byte enables. The buffer address is taken to be word aligned.

Top module: `rxd_dma`

## Requirements
- R1: When a frame starts, the engine reads the status word at the current descriptor (offset 0). If bit 31 (ownership) is set, it reads the control word (offset 4) and then the buffer address (offset 8). The frame is stored with byte n at buffer address + n, written as 32-bit words: byte n goes in lane n mod 4, unused lanes are zero, and the byte enables mark only the lanes written.
- R2: The status word is the last memory write for a received frame. It is written at descriptor offset 0 with all byte enables set. Bit 31 is 0, bit 8 is 1 (last segment), and every other bit is 0 except the length field and bit 15.
- R3: Status bits 31:16 hold the number of bytes received for the frame, counting the trailing 4-byte CRC. The count saturates at 0x7FFF, so bit 31 always reads 0.
- R4: If `rx_err` is high on the last byte, status bit 15 (error summary) is set.
- R5: The buffer size is control word bits LEN_W-1:0. If a frame is longer than this, only the first buffer-size bytes are written. Bit 15 is set, and the length field still counts every byte received.
- R6: After a write-back, the next descriptor is at the current address + 16. If control bit 25 (end of ring) was set, the next descriptor is the ring base instead.
- R7: If the current descriptor's ownership bit is clear, the engine consumes and discards the frame. It makes no write and no further read, and it reads the same descriptor again at the next frame start.
- R8: While `ctl_run` is low, incoming bytes are accepted and discarded and no memory access is made. When `ctl_run` rises, the descriptor pointer is set to `ring_base`.
- R9: After reset, `mem_req` is 0, and `rx_ready` is 1 while `ctl_run` is low.
- R10: A memory request keeps its address and direction stable until it is acknowledged. `rx_ready` is low whenever a request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_run | input | 1 | Receive enable (start-receive control bit) |
| ring_base | input | AW | Byte address of descriptor 0 |
| rx_valid | input | 1 | Frame byte present |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Byte is the last of its frame |
| rx_err | input | 1 | Frame is bad; sampled with the last byte |
| rx_ready | output | 1 | Engine accepts the byte this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the 32-bit word |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_ack | input | 1 | Access done; read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The first frames use lengths of 13 and 8 bytes. The odd length tests the partial last word and its byte enables; the error flag on the 8-byte frame shows that bit 15 comes only from `rx_err`. A 15-byte frame into a 10-byte buffer on the end-of-ring descriptor tests truncation against the full length count, and also tests the wrap back to the base. A frame offered to a host-owned descriptor, followed by a frame after the host returns ownership, shows that the drop makes no access and that the same descriptor is polled again. A frame sent while stopped, followed by a restart, tests the silent discard and the pointer reload, and separates both from normal advance.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int WORD_W     = 32;
  localparam int BE_W       = WORD_W / 8;
  localparam int DESC_BYTES = 16;
  localparam int OWN_BIT    = 31;
  localparam int WRAP_BIT   = 25;
  localparam int LENCNT_W   = 15;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_STAT, S_RD_CTRL, S_RD_BUF,
    S_RECV, S_WR_DATA, S_WR_STAT, S_DROP
  } rxd_state_e;

  function automatic logic [WORD_W-1:0] stat_word(input logic [LENCNT_W-1:0] len,
                                                  input logic es);
    return {1'b0, len, es, 6'b0, 1'b1, 8'b0};
  endfunction
endpackage

// File: rtl/rxd_ring_ptr.sv
module rxd_ring_ptr #(
  parameter int AW   = 32,
  parameter int STEP = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic          adv,
  input  logic          wrap,
  output logic [AW-1:0] cur
);
  logic [AW-1:0] base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cur    <= '0;
    end else if (load) begin
      base_q <= base;
      cur    <= base;
    end else if (adv) begin
      cur <= wrap ? base_q : cur + AW'(STEP);
    end
  end
endmodule

// File: rtl/rxd_byte_pack.sv
module rxd_byte_pack #(
  parameter int WW = 32,
  localparam int NB = WW / 8,
  localparam int LW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [LW-1:0] lane,
  input  logic [7:0]    din,
  output logic [WW-1:0] word,
  output logic [NB-1:0] be
);
  logic [WW-1:0] word_q;
  logic [NB-1:0] be_q;

  always_comb begin
    word = word_q;
    be   = be_q;
    if (push) begin
      for (int i = 0; i < NB; i++) begin
        if (lane == LW'(i)) begin
          word[8*i +: 8] = din;
          be[i]          = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      word_q <= '0;
      be_q   <= '0;
    end else if (push) begin
      word_q <= word;
      be_q   <= be;
    end
  end
endmodule

// File: rtl/rxd_dma.sv
module rxd_dma #(
  parameter int AW    = 32,
  parameter int LEN_W = 11
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ctl_run,
  input  logic [AW-1:0]            ring_base,
  input  logic                     rx_valid,
  input  logic [7:0]               rx_data,
  input  logic                     rx_last,
  input  logic                     rx_err,
  output logic                     rx_ready,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [AW-1:0]            mem_addr,
  output logic [rxd_pkg::WORD_W-1:0] mem_wdata,
  output logic [rxd_pkg::BE_W-1:0] mem_be,
  input  logic                     mem_ack,
  input  logic [rxd_pkg::WORD_W-1:0] mem_rdata
);
  import rxd_pkg::*;
  localparam int CW = LENCNT_W;

  rxd_state_e    st;
  logic          run_q;
  logic [AW-1:0] cur;
  logic [LEN_W-1:0] bsize;
  logic          wrap_q, es_q, done_q;
  logic [AW-1:0] waddr;
  logic [CW-1:0] cnt, cnt_nx;
  logic          take, store, es_nx, flush, adv;
  logic [WORD_W-1:0] pk_word;
  logic [BE_W-1:0]   pk_be;

  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= ctl_run;
  end

  assign adv = (st == S_WR_STAT) && mem_ack;

  rxd_ring_ptr #(.AW(AW), .STEP(DESC_BYTES)) u_ptr (
    .clk(clk), .rst(rst), .load(ctl_run && !run_q), .base(ring_base),
    .adv(adv), .wrap(wrap_q), .cur(cur)
  );

  assign rx_ready = ((st == S_IDLE) && !run_q) || (st == S_RECV) || (st == S_DROP);
  assign take     = rx_valid && rx_ready;
  assign store    = cnt < CW'(bsize);
  assign cnt_nx   = (&cnt) ? cnt : cnt + CW'(1);
  assign es_nx    = es_q || !store || (rx_last && rx_err);

  rxd_byte_pack #(.WW(WORD_W)) u_pack (
    .clk(clk), .rst(rst),
    .clr((st == S_RD_BUF) || flush),
    .push(take && (st == S_RECV) && store),
    .lane(cnt[1:0]), .din(rx_data),
    .word(pk_word), .be(pk_be)
  );

  assign flush = take && (st == S_RECV) &&
                 ((store && (cnt[1:0] == 2'd3)) || (rx_last && (|pk_be)));

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_be    <= '0;
      bsize     <= '0;
      wrap_q    <= 1'b0;
      es_q      <= 1'b0;
      done_q    <= 1'b0;
      waddr     <= '0;
      cnt       <= '0;
    end else begin
      case (st)
        S_IDLE: if (ctl_run && run_q && rx_valid) begin
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= cur;
          st       <= S_RD_STAT;
        end
        S_RD_STAT: if (mem_ack) begin
          if (mem_rdata[OWN_BIT]) begin
            mem_addr <= cur + AW'(4);
            st       <= S_RD_CTRL;
          end else begin
            mem_req <= 1'b0;
            st      <= S_DROP;
          end
        end
        S_RD_CTRL: if (mem_ack) begin
          bsize    <= mem_rdata[LEN_W-1:0];
          wrap_q   <= mem_rdata[WRAP_BIT];
          mem_addr <= cur + AW'(8);
          st       <= S_RD_BUF;
        end
        S_RD_BUF: if (mem_ack) begin
          mem_req <= 1'b0;
          waddr   <= mem_rdata[AW-1:0];
          cnt     <= '0;
          es_q    <= 1'b0;
          st      <= S_RECV;
        end
        S_RECV: if (take) begin
          cnt  <= cnt_nx;
          es_q <= es_nx;
          if (flush) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= waddr;
            mem_wdata <= pk_word;
            mem_be    <= pk_be;
            waddr     <= waddr + AW'(4);
            done_q    <= rx_last;
            st        <= S_WR_DATA;
          end else if (rx_last) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= cur;
            mem_wdata <= stat_word(cnt_nx, es_nx);
            mem_be    <= '1;
            st        <= S_WR_STAT;
          end
        end
        S_WR_DATA: if (mem_ack) begin
          if (done_q) begin
            mem_addr  <= cur;
            mem_wdata <= stat_word(cnt, es_q);
            mem_be    <= '1;
            st        <= S_WR_STAT;
          end else begin
            mem_req <= 1'b0;
            st      <= S_RECV;
          end
        end
        S_WR_STAT: if (mem_ack) begin
          mem_req <= 1'b0;
          mem_we  <= 1'b0;
          st      <= S_IDLE;
        end
        S_DROP: if (take && rx_last) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxd_dma_chk.sv
module rxd_dma_chk #(
  parameter int AW = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                ctl_run,
  input logic                rx_ready,
  input logic                mem_req,
  input logic                mem_we,
  input logic                mem_ack,
  input logic [AW-1:0]       mem_addr,
  input logic [31:0]         mem_wdata,
  input rxd_pkg::rxd_state_e st
);
  import rxd_pkg::*;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10

  AST_NO_RX_DURING_ACCESS: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !rx_ready); // R10

  AST_STATUS_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && st == S_WR_STAT) |-> (!mem_wdata[31] && mem_wdata[8])); // R2

  AST_STATUS_LAST: assert property (@(posedge clk) disable iff (rst)
    (st == S_WR_STAT && mem_req && mem_ack) |=> (st == S_IDLE && !mem_req)); // R2

  AST_DROP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st == S_DROP) |-> !mem_req); // R7

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!ctl_run && $past(!ctl_run) && st == S_IDLE) |=> !mem_req); // R8
endmodule

bind rxd_dma rxd_dma_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .ctl_run(ctl_run), .rx_ready(rx_ready),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .st(st)
);

// File: tb/tb_rxd_dma.sv
module tb_rxd_dma;
  localparam int AW = 32;
  localparam logic [31:0] BASE = 32'h1000;

  logic clk = 1'b0, rst = 1'b1, ctl_run = 1'b0;
  logic rx_valid = 1'b0, rx_last = 1'b0, rx_err = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_ready, mem_req, mem_we, mem_ack = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic [3:0] mem_be;

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] mem [int unsigned];
  logic [31:0] ptr;

  logic        ex_we [$];
  logic [31:0] ex_addr [$];
  logic [31:0] ex_data [$];
  logic [3:0]  ex_be [$];
  string       ex_tag [$];

  always #4 clk = ~clk;

  rxd_dma #(.AW(AW), .LEN_W(11)) dut (
    .clk(clk), .rst(rst), .ctl_run(ctl_run), .ring_base(BASE),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_err(rx_err),
    .rx_ready(rx_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a >> 2) ? mem[a >> 2] : 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic push_ex(input logic we, input logic [31:0] a, input logic [31:0] d,
                         input logic [3:0] be, input string tag);
    ex_we.push_back(we); ex_addr.push_back(a); ex_data.push_back(d);
    ex_be.push_back(be); ex_tag.push_back(tag);
  endtask

  // Memory and per-access comparison against the reference model
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      mem_ack = 1'b1;
      if (!ctl_run) begin
        checks++; errors++;
        $display("FAIL R8: access at %h while stopped, expected none", mem_addr);
      end
      if (ex_we.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7: unexpected access we=%0b addr %h, expected none", mem_we, mem_addr);
      end else begin
        string t; t = ex_tag.pop_front();
        check({t, " direction"}, {31'b0, mem_we}, {31'b0, ex_we.pop_front()});
        check({t, " address"}, mem_addr, ex_addr.pop_front());
        if (mem_we) begin
          check({t, " data"}, mem_wdata, ex_data.pop_front());
          check({t, " byte enables"}, {28'b0, mem_be}, {28'b0, ex_be.pop_front()});
        end else begin
          void'(ex_data.pop_front()); void'(ex_be.pop_front());
        end
      end
      if (mem_we) begin
        logic [31:0] w; w = rd(mem_addr);
        for (int b = 0; b < 4; b++) if (mem_be[b]) w[8*b +: 8] = mem_wdata[8*b +: 8];
        mem[mem_addr >> 2] = w;
      end else mem_rdata = rd(mem_addr);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  task automatic set_desc(input logic [31:0] d, input bit own, input bit wrap,
                          input int bsize, input logic [31:0] buff);
    mem[d >> 2]       = own ? 32'h8000_0000 : 32'h0;
    mem[(d >> 2) + 1] = (wrap ? 32'h0200_0000 : 32'h0) | 32'(bsize);
    mem[(d >> 2) + 2] = buff;
    mem[(d >> 2) + 3] = 32'h0;
  endtask

  // Reference model: predicts every access of one frame
  task automatic model_frame(input int len, input logic [7:0] seed, input bit err, input string tag);
    logic [31:0] ctrl, buff, d;
    int bs, n;
    bit es;
    push_ex(1'b0, ptr, 0, 0, {tag, " R1 status read"});
    if (!rd(ptr)[31]) return;
    ctrl = rd(ptr + 4); buff = rd(ptr + 8);
    push_ex(1'b0, ptr + 4, 0, 0, {tag, " R1 control read"});
    push_ex(1'b0, ptr + 8, 0, 0, {tag, " R1 buffer read"});
    bs = int'(ctrl[10:0]);
    n  = (len < bs) ? len : bs;
    for (int k = 0; 4 * k < n; k++) begin
      logic [3:0] be; be = '0; d = '0;
      for (int i = 0; i < 4; i++)
        if (4 * k + i < n) begin d[8*i +: 8] = seed + 8'(4 * k + i); be[i] = 1'b1; end
      push_ex(1'b1, buff + 32'(4 * k), d, be, {tag, " R1 data write"});
    end
    es = err || (len > bs);
    push_ex(1'b1, ptr, {1'b0, 15'(len), es, 6'b0, 1'b1, 8'b0}, 4'hF, {tag, " R2 R3 status write"});
    ptr = ctrl[25] ? BASE : ptr + 16;
  endtask

  task automatic send_frame(input int len, input logic [7:0] seed, input bit err);
    for (int i = 0; i < len; i++) begin
      rx_valid = 1'b1; rx_data = seed + 8'(i);
      rx_last = (i == len - 1); rx_err = err && (i == len - 1);
      forever begin
        bit t; t = rx_ready;
        @(negedge clk);
        if (t) break;
      end
    end
    rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  initial begin
    logic [31:0] keep;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 mem_req after reset", {31'b0, mem_req}, 32'h0);
    check("R9 rx_ready while stopped", {31'b0, rx_ready}, 32'h1);

    set_desc(BASE,      1, 0, 64, 32'h2000);
    set_desc(BASE + 16, 1, 0, 64, 32'h2100);
    set_desc(BASE + 32, 1, 1, 10, 32'h2200);
    ctl_run = 1'b1; ptr = BASE;
    repeat (3) @(negedge clk);

    model_frame(13, 8'h10, 0, "A"); send_frame(13, 8'h10, 0);
    check("R3 length of 13-byte frame", {16'b0, rd(BASE)[31:16]}, 32'd13);
    check("R2 ownership released", {31'b0, rd(BASE)[31]}, 32'h0);
    model_frame(8, 8'h40, 1, "B"); send_frame(8, 8'h40, 1);
    check("R4 error summary on bad frame", {31'b0, rd(BASE + 16)[15]}, 32'h1);
    model_frame(15, 8'h80, 0, "C"); send_frame(15, 8'h80, 0);
    check("R5 truncated frame status", rd(BASE + 32), 32'h000F_8100);
    check("R5 byte past buffer untouched", rd(32'h2208), 32'h0000_8988);

    keep = rd(BASE);
    model_frame(6, 8'hA0, 0, "D"); send_frame(6, 8'hA0, 0);
    check("R7 host-owned descriptor unchanged", rd(BASE), keep);
    set_desc(BASE, 1, 0, 64, 32'h2000);
    model_frame(5, 8'hC0, 0, "E"); send_frame(5, 8'hC0, 0);
    check("R7 re-polled descriptor filled", rd(BASE), 32'h0005_0100);
    check("R6 pointer moved to next slot", ptr, BASE + 16);

    ctl_run = 1'b0;
    repeat (3) @(negedge clk);
    send_frame(9, 8'h20, 0);
    check("R8 nothing written while stopped", rd(BASE + 16), 32'h0008_8100);
    set_desc(BASE, 1, 0, 64, 32'h2300);
    ctl_run = 1'b1; ptr = BASE;
    repeat (3) @(negedge clk);
    model_frame(7, 8'h55, 0, "G"); send_frame(7, 8'h55, 0);
    check("R8 restart resumes at ring base", rd(BASE), 32'h0007_0100);
    check("R1 restart frame data", rd(32'h2300), 32'h5857_5655);

    check("R2 all predicted accesses seen", 32'(ex_we.size()), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule